// File: doc/BRIEF.md
# Fault Recovery Hold-Off Timer

This block sits between a power output stage and the logic that enables it. When the stage reports a fault, the block pulls its active-low enable output low combinationally, in the same cycle, so that the stage is switched off without waiting for any register. The enable stays low while the fault persists. Once the fault has cleared, it stays low for a further programmable number of time ticks. The enable returns high only after a full, uninterrupted delay period with no fault present.

The delay is a 16-bit count of ticks. A prescaler produces the ticks by dividing the system clock by a parameterised clocks-per-tick value, chosen so that one tick lasts about 0.083 ms at the clock frequency in use. The delay is held as two bytes on a simple register bus. The same bus exposes a read-only status byte that reports the live fault and thermal-warning inputs as active-low indicator bits.

Top module: `fault_holdoff`

## Requirements
- R1: After reset, address 0x2B (delay high byte) reads 0x00, address 0x2C (delay low byte) reads 0x0C, and address 0x2D (status) reads 0x03 when no fault and no warning are present.
- R2: A bus write (bus_valid=1, bus_write=1) to 0x2B sets bits 15:8 of the delay, and a write to 0x2C sets bits 7:0. Each byte reads back the value written.
- R3: Read data appears on bus_rdata in the cycle after the read request (bus_valid=1, bus_write=0). It reads 0x00 for any unmapped address and in every cycle that does not follow a read request.
- R4: While fault_i is 1, tristate_n is 0 in the same cycle, with no clock edge needed.
- R5: After fault_i falls, tristate_n stays 0 for exactly N*P rising clock edges, where N is the programmed delay and P is the CLKS_PER_TICK parameter. It then returns to 1.
- R6: If the fault returns during a hold-off, the count restarts, and the release again takes a full N*P edges from the last time fault_i falls.
- R7: A programmed delay of 0 behaves as a delay of 1 tick.
- R8: Status bit 1 reads the inverse of fault_i and status bit 0 reads the inverse of twarn_i, as sampled in the request cycle. Bits 7:2 read 0.
- R9: Writes to 0x2D change neither the status readback nor the delay value.
- R10: With no fault and no hold-off in progress (including right after reset), tristate_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Fault reported by the power stage, active high |
| twarn_i | input | 1 | Thermal warning from the power stage, active high |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the request |
| tristate_n | output | 1 | Power stage enable, low = stage held off |

## Verification
If the hold-off counter were loaded, decremented or cleared wrongly, the error would show as a change in the release time of tristate_n. That release would come some multiple of P edges early or late after the fault falls, so it is visible within one delay period. A prescaler that ran during the fault, or failed to restart, would shift the release by a fraction of a tick. A wrong read path shows up on bus_rdata on the very next cycle. Because the status reads follow the live inputs, a latched or inverted indicator shows up on the first read after an input changes.

// File: rtl/fh_pkg.sv
package fh_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 8;
  localparam int unsigned DLY_W  = 16;

  localparam logic [REG_AW-1:0] ADDR_DLY_HI = 8'h2B;
  localparam logic [REG_AW-1:0] ADDR_DLY_LO = 8'h2C;
  localparam logic [REG_AW-1:0] ADDR_STATUS = 8'h2D;

  localparam logic [DLY_W-1:0] DLY_RESET = 16'h000C;

  // Delay actually loaded into the hold-off counter: zero means one tick.
  function automatic logic [DLY_W-1:0] eff_delay(input logic [DLY_W-1:0] d);
    return (d == '0) ? DLY_W'(1) : d;
  endfunction

  // Active-low indicator byte: bit1 fault, bit0 thermal warning.
  function automatic logic [REG_DW-1:0] status_byte(input logic flt, input logic warn);
    return {6'b0, ~flt, ~warn};
  endfunction
endpackage

// File: rtl/fh_prescaler.sv
module fh_prescaler #(
  parameter int unsigned CLKS_PER_TICK = 20750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);

  logic [PW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + PW'(1);
  end

  generate
    if (CLKS_PER_TICK > 1) begin : g_gap
      // R5: ticks are spaced by the full prescale period, never back to back
      p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/fh_holdoff_timer.sv
module fh_holdoff_timer
  import fh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_i,
  input  logic             tick,
  input  logic [DLY_W-1:0] delay,
  output logic             hold_active,
  output logic [DLY_W-1:0] hold_cnt
);
  logic last_tick;
  assign last_tick = hold_active && !fault_i && tick && (hold_cnt == DLY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_active <= 1'b0;
      hold_cnt    <= '0;
    end else if (fault_i) begin
      hold_active <= 1'b1;
      hold_cnt    <= eff_delay(delay);
    end else if (hold_active && tick) begin
      if (last_tick) begin
        hold_active <= 1'b0;
        hold_cnt    <= '0;
      end else begin
        hold_cnt    <= hold_cnt - DLY_W'(1);
      end
    end
  end

  // R6: a fault always (re)starts the hold-off
  p_fault_arms_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> hold_active);
  // R7: counter is never zero while holding, so zero delay acts as one tick
  p_cnt_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (hold_cnt != '0));
  // R5: release happens only on a tick with the fault absent
  p_release_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> $past(tick && !fault_i));
endmodule

// File: rtl/fh_regs.sv
module fh_regs
  import fh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [REG_DW-1:0] bus_wdata,
  input  logic [REG_DW-1:0] status,
  output logic [REG_DW-1:0] bus_rdata,
  output logic [DLY_W-1:0]  delay
);
  logic [REG_DW-1:0] dly_hi, dly_lo, rd_mux;
  logic wr_req, rd_req, wr_status;

  assign wr_req    = bus_valid && bus_write;
  assign rd_req    = bus_valid && !bus_write;
  assign wr_status = wr_req && (bus_addr == ADDR_STATUS);
  assign delay     = {dly_hi, dly_lo};

  always_comb begin
    case (bus_addr)
      ADDR_DLY_HI: rd_mux = dly_hi;
      ADDR_DLY_LO: rd_mux = dly_lo;
      ADDR_STATUS: rd_mux = status;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_hi    <= DLY_RESET[15:8];
      dly_lo    <= DLY_RESET[7:0];
      bus_rdata <= '0;
    end else begin
      if (wr_req && bus_addr == ADDR_DLY_HI) dly_hi <= bus_wdata;
      if (wr_req && bus_addr == ADDR_DLY_LO) dly_lo <= bus_wdata;
      bus_rdata <= rd_req ? rd_mux : '0;
    end
  end

  // R9: a write to the status address leaves the delay untouched
  p_status_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> $stable(delay));
  // R3: read data is nonzero only in the cycle after a read request
  p_rdata_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (bus_rdata == '0));
endmodule

// File: rtl/fault_holdoff.sv
module fault_holdoff
  import fh_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 20750
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_i,
  input  logic       twarn_i,
  input  logic       bus_valid,
  input  logic       bus_write,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tristate_n
);
  logic [DLY_W-1:0] delay;
  logic [DLY_W-1:0] hold_cnt;
  logic             hold_active;
  logic             tick;
  logic             pre_run;
  logic [REG_DW-1:0] status;

  assign status     = status_byte(fault_i, twarn_i);
  assign pre_run    = hold_active && !fault_i;
  assign tristate_n = !(fault_i || hold_active);

  fh_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status),
    .bus_rdata (bus_rdata),
    .delay     (delay)
  );

  fh_prescaler #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (pre_run),
    .tick  (tick)
  );

  fh_holdoff_timer u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_i     (fault_i),
    .tick        (tick),
    .delay       (delay),
    .hold_active (hold_active),
    .hold_cnt    (hold_cnt)
  );

  // R4: a sampled fault always sees the output low at that edge
  p_fault_forces_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |-> !tristate_n);
  // R10: enable rises only at the end of a hold-off with no fault present
  p_rise_after_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tristate_n) |-> ($past(hold_active) && !fault_i));
endmodule

// File: tb/sim_fault_holdoff.sv
module sim_fault_holdoff;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fault_i = 1'b0, twarn_i = 1'b0;
  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tristate_n;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  fault_holdoff #(.CLKS_PER_TICK(P)) u0 (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .twarn_i(twarn_i),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tristate_n(tristate_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares read data one cycle after each request
  always @(posedge clk) begin
    logic req;
    req = bus_valid && !bus_write && rst_n;
    #1;
    if (req) begin
      if (exp_q.size() == 0) check("R3 unexpected read", 1, 0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end else if (rst_n) begin
      if (bus_rdata != 8'h00) check("R3 idle rdata", bus_rdata, 0);
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  // Drop the fault and count rising edges until the enable returns high
  task automatic measure(input int exp_edges, input string req);
    int n = 0;
    @(negedge clk);
    fault_i = 0;
    while (n < 200000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (tristate_n) break;
    end
    check(req, n, exp_edges);
  endtask

  task automatic fault_pulse(input int cycles);
    @(negedge clk);
    fault_i = 1;
    #1 check("R4 same-cycle low", tristate_n, 0);
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #150000;
    check("watchdog", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R10 reset output", tristate_n, 1);
    rst_n = 1;
    @(negedge clk);
    check("R10 idle output", tristate_n, 1);
    rd(8'h2B, 8'h00, "R1 hi reset");
    rd(8'h2C, 8'h0C, "R1 lo reset");
    rd(8'h2D, 8'h03, "R1 status reset");
    rd(8'h40, 8'h00, "R3 unmapped");

    // Default delay of 12 ticks
    fault_pulse(3);
    measure(12 * P, "R5 default delay");

    // Programmed delay
    wr(8'h2B, 8'h00); wr(8'h2C, 8'h05);
    rd(8'h2C, 8'h05, "R2 lo readback");
    wr(8'h2B, 8'h01);
    rd(8'h2B, 8'h01, "R2 hi readback");
    wr(8'h2B, 8'h00);
    fault_pulse(1);
    measure(5 * P, "R5 delay 5");

    // Fault returns mid hold-off
    fault_pulse(2);
    @(negedge clk); fault_i = 0;
    repeat (7) @(negedge clk);
    check("R6 still low", tristate_n, 0);
    fault_pulse(1);
    measure(5 * P, "R6 restart");

    // Zero delay
    wr(8'h2C, 8'h00);
    fault_pulse(2);
    measure(1 * P, "R7 zero delay");

    // Status indicators
    @(negedge clk); twarn_i = 1;
    rd(8'h2D, 8'h02, "R8 warning");
    @(negedge clk); twarn_i = 0; fault_i = 1;
    rd(8'h2D, 8'h01, "R8 fault");
    @(negedge clk); twarn_i = 1;
    rd(8'h2D, 8'h00, "R8 both");
    @(negedge clk); twarn_i = 0;
    measure(1 * P, "R7 zero delay again");
    rd(8'h2D, 8'h03, "R8 cleared");

    // Writes to status ignored
    wr(8'h2D, 8'hFF);
    rd(8'h2D, 8'h03, "R9 status after write");
    rd(8'h2C, 8'h00, "R9 delay lo unchanged");
    rd(8'h2B, 8'h00, "R9 delay hi unchanged");
    @(negedge clk);
    check("R10 idle after all", tristate_n, 1);

    repeat (3) @(negedge clk);
    check("R3 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule